// File: doc/BRIEF.md
# SDRAM Bank Command State Tracker

This block watches the control pins of a synchronous DRAM interface every clock. It keeps a small state machine for each internal bank, and each bank is in one of five states: idle, row open, reading, writing, or write recovery. On every rising edge it decodes the chip-select, row-strobe, column-strobe and write-enable levels into a command. It checks that command against the state of the bank that the bank-select bits address, or against every bank when the command is chip-wide. It then moves the affected banks to their next state.

A controller or protocol monitor places it beside the memory command bus. The burst engine supplies a one-cycle burst-complete pulse, and the tracker uses it to close read and write bursts. The tracker registers three outputs one cycle after the command: the decoded command code, a flag that marks a command as not allowed in the current state, and the packed per-bank state. An illegal command leaves every bank unchanged. The write-recovery length and the bank count are parameters.

Top module: `sdram_bank_tracker`

## Requirements
- R1: `cmd_o` gives the command sampled at the previous edge, with these codes: 0 deselect (chip select high), 1 no-op (row,col,we = H H H), 2 burst stop (H H L), 3 read (H L H), 4 write (H L L), 5 activate (L H H), 6 precharge (L H L), 7 refresh (L L H), 8 mode set (L L L).
- R2: During and right after reset, every bank reads idle, `illegal_o` is 0 and `cmd_o` is 0. Bank n occupies `bank_state_o[3n+2:3n]`, with the codes 0 idle, 1 row open, 2 reading, 3 writing, 4 write recovery.
- R3: When the addressed bank is idle, read and write are illegal, activate moves it to row open, and precharge is a legal no-op.
- R4: When the addressed bank is open, activate is illegal, read moves it to reading, write moves it to writing, and precharge returns it to idle.
- R5: Refresh and mode set are legal only while all banks are idle. In any other case they are flagged.
- R6: A flagged command changes no bank state. Activate is flagged in the reading, writing and recovery states.
- R7: A reading bank goes to row open on the burst-complete pulse, or to idle if auto-precharge was requested. A burst stop moves every reading or writing bank to row open at once.
- R8: A writing bank enters write recovery on burst-complete. It stays there for WR_CYC cycles (default 2) and then goes to row open, or to idle with auto-precharge.
- R9: Read or write in the reading, writing or recovery state restarts a burst. On every read or write, A10 sets (1) or clears (0) the bank's auto-precharge request.
- R10: Precharge with A10 high sends every bank to idle. With A10 low it affects only the addressed bank, and it ends any burst in progress.
- R11: Activate, read and write change only the addressed bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe level |
| cas_n | input | 1 | Column strobe level |
| we_n | input | 1 | Write enable level |
| ba | input | 2 | Bank select |
| a10 | input | 1 | Auto-precharge / all-banks bit |
| burst_done | input | 1 | Burst-complete pulse from the burst engine |
| bank_state_o | output | 12 | Packed state of all banks, 3 bits each |
| illegal_o | output | 1 | Previous command was not allowed |
| cmd_o | output | 4 | Code of previous command |

## Verification
A bank held in the wrong state shows up as a wrong 3-bit field on `bank_state_o` one edge after the command that caused it. The next command sent to that bank also gets a wrong verdict on `illegal_o` one edge after it is issued. A lost auto-precharge request only becomes visible when the burst closes, where the bank lands in row open instead of idle. For that reason, the stimulus ends each burst and inspects the landing state. Write recovery is checked on each cycle of its window, so a counter that runs one cycle long or short shows up at the exit edge.

// File: rtl/sdtrk_pkg.sv
package sdtrk_pkg;

  typedef enum logic [3:0] {
    C_DESEL = 4'd0,
    C_NOP   = 4'd1,
    C_BSTOP = 4'd2,
    C_READ  = 4'd3,
    C_WRITE = 4'd4,
    C_ACT   = 4'd5,
    C_PRE   = 4'd6,
    C_REF   = 4'd7,
    C_MRS   = 4'd8
  } cmd_e;

  typedef enum logic [2:0] {
    B_IDLE = 3'd0,
    B_OPEN = 3'd1,
    B_RD   = 3'd2,
    B_WR   = 3'd3,
    B_WREC = 3'd4
  } bstate_e;

  // Pin levels to command.
  function automatic cmd_e decode_pins(logic cs_n, logic ras_n, logic cas_n, logic we_n);
    if (cs_n) return C_DESEL;
    case ({ras_n, cas_n, we_n})
      3'b111:  return C_NOP;
      3'b110:  return C_BSTOP;
      3'b101:  return C_READ;
      3'b100:  return C_WRITE;
      3'b011:  return C_ACT;
      3'b010:  return C_PRE;
      3'b001:  return C_REF;
      default: return C_MRS;
    endcase
  endfunction

  // Legality of a command given the addressed bank and the whole-chip idle flag.
  function automatic logic cmd_ok(cmd_e c, bstate_e s, logic all_idle);
    case (c)
      C_READ, C_WRITE: return s != B_IDLE;
      C_ACT:           return s == B_IDLE;
      C_REF, C_MRS:    return all_idle;
      default:         return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/sdtrk_decode.sv
module sdtrk_decode
  import sdtrk_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  assign cmd = decode_pins(cs_n, ras_n, cas_n, we_n);
endmodule

// File: rtl/sdtrk_bank.sv
module sdtrk_bank
  import sdtrk_pkg::*;
#(
  parameter int WR_CYC = 2,
  localparam int CW = (WR_CYC > 1) ? $clog2(WR_CYC) : 1
) (
  input  logic    clk,
  input  logic    rst_n,
  input  cmd_e    cmd,
  input  logic    hit,
  input  logic    a10,
  input  logic    ok,
  input  logic    burst_done,
  output bstate_e state
);

  bstate_e        st_q, st_d;
  logic           ap_q, ap_d;
  logic [CW-1:0]  cnt_q, cnt_d;

  // Named events.
  logic take, start_burst, open_row, close_row, stop_burst, burst_end, wrec_exit;

  assign take        = ok && (hit || (cmd == C_PRE && a10) || cmd == C_BSTOP);
  assign start_burst = take && hit && (cmd == C_READ || cmd == C_WRITE);
  assign open_row    = take && hit && cmd == C_ACT;
  assign close_row   = take && cmd == C_PRE;
  assign stop_burst  = take && cmd == C_BSTOP && (st_q == B_RD || st_q == B_WR);
  assign burst_end   = burst_done && (st_q == B_RD || st_q == B_WR);
  assign wrec_exit   = (st_q == B_WREC) && (cnt_q == '0);

  always_comb begin
    st_d  = st_q;
    ap_d  = ap_q;
    cnt_d = cnt_q;
    if (start_burst) begin
      st_d = (cmd == C_READ) ? B_RD : B_WR;
      ap_d = a10;
    end else if (open_row) begin
      st_d = B_OPEN;
    end else if (close_row) begin
      st_d = B_IDLE;
      ap_d = 1'b0;
    end else if (stop_burst) begin
      st_d = B_OPEN;
      ap_d = 1'b0;
    end else if (burst_end && st_q == B_RD) begin
      st_d = ap_q ? B_IDLE : B_OPEN;
      ap_d = 1'b0;
    end else if (burst_end) begin
      st_d  = B_WREC;
      cnt_d = CW'(WR_CYC - 1);
    end else if (wrec_exit) begin
      st_d = ap_q ? B_IDLE : B_OPEN;
      ap_d = 1'b0;
    end else if (st_q == B_WREC) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= B_IDLE;
      ap_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      ap_q  <= ap_d;
      cnt_q <= cnt_d;
    end
  end

  assign state = st_q;

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdtrk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int WR_CYC    = 2,
  localparam int BA_W = $clog2(NUM_BANKS),
  localparam int SW   = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic                    ras_n,
  input  logic                    cas_n,
  input  logic                    we_n,
  input  logic [BA_W-1:0]         ba,
  input  logic                    a10,
  input  logic                    burst_done,
  output logic [NUM_BANKS*SW-1:0] bank_state_o,
  output logic                    illegal_o,
  output logic [3:0]              cmd_o
);

  cmd_e    cmd_now;
  bstate_e st [NUM_BANKS];
  logic    all_idle;
  logic    cmd_legal;

  sdtrk_decode u_dec (
    .cs_n (cs_n),
    .ras_n(ras_n),
    .cas_n(cas_n),
    .we_n (we_n),
    .cmd  (cmd_now)
  );

  always_comb begin
    all_idle = 1'b1;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (st[i] != B_IDLE) all_idle = 1'b0;
    end
  end

  assign cmd_legal = cmd_ok(cmd_now, st[ba], all_idle);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    sdtrk_bank #(.WR_CYC(WR_CYC)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd       (cmd_now),
      .hit       (ba == BA_W'(g)),
      .a10       (a10),
      .ok        (cmd_legal),
      .burst_done(burst_done),
      .state     (st[g])
    );
    assign bank_state_o[g*SW +: SW] = st[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      illegal_o <= 1'b0;
      cmd_o     <= C_DESEL;
    end else begin
      illegal_o <= !cmd_legal;
      cmd_o     <= cmd_now;
    end
  end

endmodule

// File: rtl/sdtrk_chk.sv
module sdtrk_chk #(
  parameter int NUM_BANKS = 4,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cs_n,
  input logic                   ras_n,
  input logic                   cas_n,
  input logic                   we_n,
  input logic [BA_W-1:0]        ba,
  input logic                   a10,
  input logic [NUM_BANKS*3-1:0] bank_state_o,
  input logic                   illegal_o,
  input logic [3:0]             cmd_o
);

  logic [2:0] tgt;
  logic       is_nop, is_read, is_pre, is_ref, is_bst;
  assign tgt     = bank_state_o[32'(ba)*3 +: 3];
  assign is_nop  = !cs_n &&  ras_n &&  cas_n &&  we_n;
  assign is_bst  = !cs_n &&  ras_n &&  cas_n && !we_n;
  assign is_read = !cs_n &&  ras_n && !cas_n &&  we_n;
  assign is_pre  = !cs_n && !ras_n &&  cas_n && !we_n;
  assign is_ref  = !cs_n && !ras_n && !cas_n &&  we_n;

  // R1
  nop_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_nop |=> (cmd_o == 4'd1));

  // R3
  read_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_read && tgt == 3'd0) |=> illegal_o);

  // R5
  ref_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ref && bank_state_o != '0) |=> illegal_o);

  // R6
  illegal_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> $stable(bank_state_o));

  // R7
  bstop_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_bst && bank_state_o[2:0] == 3'd2) |=> (bank_state_o[2:0] == 3'd1));

  // R10
  pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pre && a10) |=> (bank_state_o == '0));

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_rng
    // R2
    state_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bank_state_o[g*3 +: 3] <= 3'd4);
  end

endmodule

bind sdram_bank_tracker sdtrk_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n        (cs_n),
  .ras_n       (ras_n),
  .cas_n       (cas_n),
  .we_n        (we_n),
  .ba          (ba),
  .a10         (a10),
  .bank_state_o(bank_state_o),
  .illegal_o   (illegal_o),
  .cmd_o       (cmd_o)
);

// File: tb/sim_sdram_bank_tracker.sv
module sim_sdram_bank_tracker;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic        a10, burst_done;
  logic [11:0] bank_state_o;
  logic        illegal_o;
  logic [3:0]  cmd_o;

  always #10 clk = ~clk;

  sdram_bank_tracker u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a10(a10), .burst_done(burst_done),
    .bank_state_o(bank_state_o), .illegal_o(illegal_o), .cmd_o(cmd_o)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  localparam logic [3:0] DS = 0, NOP = 1, BST = 2, RD = 3, WR = 4,
                         ACT = 5, PRE = 6, REF = 7, MRS = 8;

  logic [2:0]  es [4];
  logic [11:0] q_st  [$];
  logic        q_ill [$];
  logic [3:0]  q_cmd [$];
  string       q_tag [$];

  function automatic logic [3:0] pins(input logic [3:0] c);
    case (c)
      DS:  return 4'b1111;
      NOP: return 4'b0111;
      BST: return 4'b0110;
      RD:  return 4'b0101;
      WR:  return 4'b0100;
      ACT: return 4'b0011;
      PRE: return 4'b0010;
      REF: return 4'b0001;
      default: return 4'b0000;
    endcase
  endfunction

  // Driver: applies one command, pushes expected outputs after the next edge.
  task automatic step(input logic [3:0] c, input logic [1:0] b, input logic a,
                      input logic d, input logic ill, input string tag);
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = pins(c);
    ba = b; a10 = a; burst_done = d;
    q_st.push_back({es[3], es[2], es[1], es[0]});
    q_ill.push_back(ill);
    q_cmd.push_back(c);
    q_tag.push_back(tag);
  endtask

  // Monitor: compares halfway between edges.
  always @(posedge clk) begin
    #5;
    if (q_st.size() > 0) begin
      logic [11:0] xs;
      logic        xi;
      logic [3:0]  xc;
      string       t;
      xs = q_st.pop_front(); xi = q_ill.pop_front();
      xc = q_cmd.pop_front(); t = q_tag.pop_front();
      checks++;
      if (bank_state_o !== xs || illegal_o !== xi || cmd_o !== xc) begin
        errors++;
        $display("FAIL %s: actual st=%h ill=%b cmd=%0d expected st=%h ill=%b cmd=%0d",
                 t, bank_state_o, illegal_o, cmd_o, xs, xi, xc);
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) es[i] = 3'd0;
    rst_n = 1'b0;
    {cs_n, ras_n, cas_n, we_n} = 4'b1111;
    ba = 2'd0; a10 = 1'b0; burst_done = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (bank_state_o !== 12'h000 || illegal_o !== 1'b0 || cmd_o !== 4'd0) begin
      errors++;
      $display("FAIL R2 reset: actual st=%h ill=%b cmd=%0d expected st=000 ill=0 cmd=0",
               bank_state_o, illegal_o, cmd_o);
    end
    rst_n = 1'b1;

    step(RD,  0, 0, 0, 1, "R3 read to idle");
    step(PRE, 0, 0, 0, 0, "R3 precharge idle");
    step(REF, 0, 0, 0, 0, "R5 refresh all idle");
    step(MRS, 0, 0, 0, 0, "R5 mode set all idle");
    es[0] = 1; step(ACT, 0, 0, 0, 0, "R3 activate");
    step(ACT, 0, 0, 0, 1, "R4 activate open");
    step(REF, 2, 0, 0, 1, "R5 refresh busy");
    es[1] = 1; step(ACT, 1, 0, 0, 0, "R11 activate bank1");
    es[0] = 2; step(RD,  0, 0, 0, 0, "R4 read starts");
    es[0] = 1; step(NOP, 0, 0, 1, 0, "R7 read done");
    es[0] = 2; step(RD,  0, 0, 0, 0, "R4 read again");
    es[0] = 1; step(BST, 3, 0, 0, 0, "R7 burst stop");
    es[1] = 3; step(WR,  1, 0, 0, 0, "R4 write starts");
    es[1] = 4; step(DS,  0, 0, 1, 0, "R8 write done");
    step(NOP, 0, 0, 0, 0, "R8 recovery hold");
    es[1] = 1; step(NOP, 0, 0, 0, 0, "R8 recovery exit");
    es[1] = 3; step(WR,  1, 1, 0, 0, "R9 write autopre");
    es[1] = 4; step(NOP, 0, 0, 1, 0, "R8 autopre recovery");
    step(NOP, 0, 0, 0, 0, "R8 autopre hold");
    es[1] = 0; step(NOP, 0, 0, 0, 0, "R8 autopre idle");
    es[0] = 2; step(RD,  0, 1, 0, 0, "R9 read autopre");
    step(RD,  0, 0, 0, 0, "R9 restart read");
    es[0] = 1; step(NOP, 0, 0, 1, 0, "R9 autopre cleared");
    es[0] = 2; step(RD,  0, 1, 0, 0, "R9 read autopre2");
    es[0] = 0; step(NOP, 0, 0, 1, 0, "R7 autopre read done");
    es[2] = 1; step(ACT, 2, 0, 0, 0, "R11 activate bank2");
    es[3] = 1; step(ACT, 3, 0, 0, 0, "R11 activate bank3");
    es[2] = 2; step(RD,  2, 0, 0, 0, "R4 read bank2");
    es[3] = 0; step(PRE, 3, 0, 0, 0, "R10 single precharge");
    es[2] = 0; step(PRE, 2, 0, 0, 0, "R10 precharge ends read");
    es[0] = 1; step(ACT, 0, 0, 0, 0, "R3 activate bank0");
    es[1] = 1; step(ACT, 1, 0, 0, 0, "R3 activate bank1");
    es[1] = 3; step(WR,  1, 0, 0, 0, "R4 write bank1");
    step(MRS, 0, 0, 0, 1, "R6 mode set busy");
    es[1] = 4; step(NOP, 0, 0, 1, 0, "R8 recovery bank1");
    es[1] = 2; step(RD,  1, 0, 0, 0, "R9 read from recovery");
    step(ACT, 1, 0, 0, 1, "R6 activate in read");
    for (int i = 0; i < 4; i++) es[i] = 0;
    step(PRE, 2, 1, 0, 0, "R10 precharge all");
    step(RD,  2, 0, 0, 1, "R3 read idle bank2");
    step(WR,  3, 0, 0, 1, "R3 write idle bank3");

    while (q_st.size() > 0) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule